// File: doc/BRIEF.md
# SMBus target transaction framer

This block sits behind an I2C target byte engine that has already matched the address. It turns bus-level events into device-level SMBus actions. The engine reports six kinds of event: a start in the write direction, a start in the read direction, a stop, a NACK from the controller, a received data byte, and a request for the next byte to transmit.

The framer collects write bytes in a buffer. It emits three kinds of device action:
- a quick command, carrying its direction bit;
- a committed write block, made of the command byte, the data bytes and the byte count;
- a fetch strobe toward a device-side read port, one for each byte transmitted.

Illegal event orderings move the framer into a sticky error mode. Only a stop clears that mode. Each protocol violation pulses an error strobe with a code that says what went wrong.

A write followed by a repeated-start read commits the buffered write before the read begins. A transfer that carries no data bytes is reported as a quick command when its stop arrives.

Top module: `smbus_txn_framer`

## Requirements
- R1: After reset the framer is idle and every strobe output is low: `quick_stb_o`, `wr_stb_o`, `fetch_stb_o`, `tx_valid_o` and `err_stb_o`.
- R2: A write-direction start in idle enters write mode. In any other mode it pulses an error with code 0 and enters error mode.
- R3: A byte received in write mode is appended to the buffer, up to `DEPTH` bytes. A byte arriving when the buffer is full is dropped and pulses an error with code 5; the mode does not change.
- R4: A stop in write mode with N>0 buffered bytes pulses `wr_stb_o` one cycle later. In that cycle `wr_cmd_o` is the first byte, `wr_len_o`=N, and buffered byte i is on `wr_data_o[8i+7:8i]`.
- R5: A stop with zero buffered bytes pulses `quick_stb_o` one cycle later. `quick_dir_o` is 0 if the mode was write and 1 if the mode was read. No other mode produces a quick command.
- R6: A read-direction start behaves as follows:
  - In idle it enters read mode.
  - In write mode with buffered bytes it pulses `wr_stb_o` (as in R4) and enters read mode.
  - In write mode with no bytes it pulses error code 2 and enters error mode.
  - In any other mode it pulses error code 1 and enters error mode.
- R7: A transmit request in read mode raises `fetch_stb_o` in the same cycle. One cycle later `tx_valid_o` pulses with `tx_data_o` equal to the `dev_rd_data_i` sampled at the request. In any other mode the request instead returns 0xFF with `tx_valid_o`, pulses error code 7 and enters error mode.
- R8: A NACK in read mode enters done mode. A NACK in done mode has no effect and no error. A NACK in any other mode pulses error code 4 and enters error mode.
- R9: Every stop returns the framer to idle and clears the byte count, including a stop from error or done mode. A stop in read mode with buffered bytes pulses error code 3 and commits nothing.
- R10: A byte received outside write mode is discarded, pulses error code 6 and leaves the mode unchanged.
- R11: Error mode is sticky. Only a stop leaves it. While in error mode, any start, NACK or transmit request pulses an error again.
- R12: When several events arrive in one cycle, only one is acted on, in this order: stop, write start, read start, NACK, byte, transmit request. The others are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_wr_i | input | 1 | Start condition, write direction |
| start_rd_i | input | 1 | Start condition, read direction |
| stop_i | input | 1 | Stop condition |
| nack_i | input | 1 | Controller NACK after a transmitted byte |
| rx_valid_i | input | 1 | Received data byte present |
| rx_byte_i | input | 8 | Received data byte |
| tx_req_i | input | 1 | Request for the next byte to transmit |
| dev_rd_data_i | input | 8 | Device read port data |
| quick_stb_o | output | 1 | Quick command strobe |
| quick_dir_o | output | 1 | Quick command direction (1 = read) |
| wr_stb_o | output | 1 | Write block commit strobe |
| wr_cmd_o | output | 8 | Command byte (first buffered byte) |
| wr_len_o | output | LENW | Buffered byte count at commit |
| wr_data_o | output | DEPTH*8 | Buffer contents, byte i in bits 8i+7:8i |
| fetch_stb_o | output | 1 | Device read fetch, same cycle as the request |
| tx_valid_o | output | 1 | Transmit byte ready |
| tx_data_o | output | 8 | Transmit byte |
| err_stb_o | output | 1 | Protocol error strobe |
| err_code_o | output | 3 | Error cause code |

## Verification
The results do not all arrive in the same cycle.
- `fetch_stb_o` is combinational, so it is checked one time unit after the request is driven, before the next rising edge.
- Every other result is registered once. Quick command, write commit, transmit byte and error strobe are due one cycle after the event.

Each scenario drives its event at a falling edge. It reads the combinational fetch shortly afterwards and reads the registered outputs at the following falling edge, which is where they are valid for their single cycle. Mode changes that no port shows directly, such as staying idle after a stray byte or staying in error mode, are checked through the response to the next event.

// File: rtl/smbus_frm_pkg.sv
package smbus_frm_pkg;

    typedef enum logic [2:0] {
        MD_IDLE     = 3'd0,
        MD_WRITE    = 3'd1,
        MD_READ     = 3'd2,
        MD_DONE     = 3'd3,
        MD_CONFUSED = 3'd4
    } mode_e;

    typedef enum logic [2:0] {
        ER_START_WR = 3'd0,
        ER_START_RD = 3'd1,
        ER_RD_EMPTY = 3'd2,
        ER_STOP_RD  = 3'd3,
        ER_NACK     = 3'd4,
        ER_OVERFLOW = 3'd5,
        ER_STRAY    = 3'd6,
        ER_TX       = 3'd7
    } err_e;

    typedef struct packed {
        logic push;
        logic clear;
        logic commit;
        logic quick;
        logic quick_dir;
        logic fetch;
        logic tx_bad;
        logic err;
        err_e code;
    } act_t;

endpackage

// File: rtl/smbus_frm_wbuf.sv
module smbus_frm_wbuf #(
    parameter int DEPTH = 34,
    parameter int LENW  = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push_i,
    input  logic                 clear_i,
    input  logic [7:0]           din_i,
    output logic [LENW-1:0]      cnt_o,
    output logic                 full_o,
    output logic [DEPTH*8-1:0]   data_o
);

    typedef struct packed {
        logic [LENW-1:0]         cnt;
        logic [DEPTH-1:0][7:0]   mem;
    } buf_t;

    buf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.cnt = '0;
        end else if (push_i && !full_o) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (st_q.cnt == LENW'(i)) st_d.mem[i] = din_i;
            end
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign full_o = (st_q.cnt == LENW'(DEPTH));

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign data_o[8*g +: 8] = st_q.mem[g];
    end

    // R3: the count never runs past the buffer depth
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LENW'(DEPTH));

    // R3: the sequencer never asks for a push into a full buffer
    assert_push_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (st_q.cnt < LENW'(DEPTH)));

endmodule

// File: rtl/smbus_frm_seq.sv
module smbus_frm_seq
    import smbus_frm_pkg::*;
#(
    parameter int LENW = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_wr_i,
    input  logic             start_rd_i,
    input  logic             stop_i,
    input  logic             nack_i,
    input  logic             rx_valid_i,
    input  logic             tx_req_i,
    input  logic [LENW-1:0]  cnt_i,
    input  logic             full_i,
    output act_t             act_o,
    output mode_e            mode_o
);

    typedef struct packed {
        mode_e mode;
    } seq_t;

    seq_t st_d, st_q;
    logic empty;

    assign empty = (cnt_i == '0);

    always_comb begin
        st_d  = st_q;
        act_o = '0;
        if (stop_i) begin
            // R9: every stop ends in idle with the count cleared
            act_o.clear = 1'b1;
            st_d.mode   = MD_IDLE;
            if (empty) begin
                if (st_q.mode == MD_WRITE || st_q.mode == MD_READ) begin
                    act_o.quick     = 1'b1;
                    act_o.quick_dir = (st_q.mode == MD_READ);
                end
            end else if (st_q.mode == MD_WRITE) begin
                act_o.commit = 1'b1;
            end else if (st_q.mode == MD_READ) begin
                act_o.err  = 1'b1;
                act_o.code = ER_STOP_RD;
            end
        end else if (start_wr_i) begin
            if (st_q.mode == MD_IDLE) begin
                st_d.mode = MD_WRITE;
            end else begin
                act_o.err  = 1'b1;
                act_o.code = ER_START_WR;
                st_d.mode  = MD_CONFUSED;
            end
        end else if (start_rd_i) begin
            case (st_q.mode)
                MD_IDLE: st_d.mode = MD_READ;
                MD_WRITE: begin
                    if (empty) begin
                        act_o.err  = 1'b1;
                        act_o.code = ER_RD_EMPTY;
                        st_d.mode  = MD_CONFUSED;
                    end else begin
                        act_o.commit = 1'b1;
                        st_d.mode    = MD_READ;
                    end
                end
                default: begin
                    act_o.err  = 1'b1;
                    act_o.code = ER_START_RD;
                    st_d.mode  = MD_CONFUSED;
                end
            endcase
        end else if (nack_i) begin
            case (st_q.mode)
                MD_READ: st_d.mode = MD_DONE;
                MD_DONE: st_d.mode = MD_DONE;
                default: begin
                    act_o.err  = 1'b1;
                    act_o.code = ER_NACK;
                    st_d.mode  = MD_CONFUSED;
                end
            endcase
        end else if (rx_valid_i) begin
            if (st_q.mode == MD_WRITE) begin
                if (full_i) begin
                    act_o.err  = 1'b1;
                    act_o.code = ER_OVERFLOW;
                end else begin
                    act_o.push = 1'b1;
                end
            end else begin
                act_o.err  = 1'b1;
                act_o.code = ER_STRAY;
            end
        end else if (tx_req_i) begin
            if (st_q.mode == MD_READ) begin
                act_o.fetch = 1'b1;
            end else begin
                act_o.tx_bad = 1'b1;
                act_o.err    = 1'b1;
                act_o.code   = ER_TX;
                st_d.mode    = MD_CONFUSED;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{mode: MD_IDLE};
        else        st_q <= st_d;
    end

    assign mode_o = st_q.mode;

    assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (st_q.mode == MD_IDLE));

    assert_sticky_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MD_CONFUSED && !stop_i) |=> (st_q.mode == MD_CONFUSED));

    assert_nack_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MD_DONE && nack_i && !stop_i && !start_wr_i && !start_rd_i)
            |-> !act_o.err);

endmodule

// File: rtl/smbus_txn_framer.sv
module smbus_txn_framer
    import smbus_frm_pkg::*;
#(
    parameter int DEPTH = 34,
    localparam int LENW = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_wr_i,
    input  logic                 start_rd_i,
    input  logic                 stop_i,
    input  logic                 nack_i,
    input  logic                 rx_valid_i,
    input  logic [7:0]           rx_byte_i,
    input  logic                 tx_req_i,
    input  logic [7:0]           dev_rd_data_i,
    output logic                 quick_stb_o,
    output logic                 quick_dir_o,
    output logic                 wr_stb_o,
    output logic [7:0]           wr_cmd_o,
    output logic [LENW-1:0]      wr_len_o,
    output logic [DEPTH*8-1:0]   wr_data_o,
    output logic                 fetch_stb_o,
    output logic                 tx_valid_o,
    output logic [7:0]           tx_data_o,
    output logic                 err_stb_o,
    output logic [2:0]           err_code_o
);

    typedef struct packed {
        logic             quick_stb;
        logic             quick_dir;
        logic             wr_stb;
        logic [LENW-1:0]  wr_len;
        logic             tx_valid;
        logic [7:0]       tx_data;
        logic             err_stb;
        logic [2:0]       err_code;
    } out_t;

    act_t             act;
    mode_e            mode;
    logic [LENW-1:0]  cnt;
    logic             full;
    out_t             out_d, out_q;

    smbus_frm_seq #(.LENW(LENW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_wr_i (start_wr_i),
        .start_rd_i (start_rd_i),
        .stop_i     (stop_i),
        .nack_i     (nack_i),
        .rx_valid_i (rx_valid_i),
        .tx_req_i   (tx_req_i),
        .cnt_i      (cnt),
        .full_i     (full),
        .act_o      (act),
        .mode_o     (mode)
    );

    smbus_frm_wbuf #(.DEPTH(DEPTH), .LENW(LENW)) u_wbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (act.push),
        .clear_i (act.clear),
        .din_i   (rx_byte_i),
        .cnt_o   (cnt),
        .full_o  (full),
        .data_o  (wr_data_o)
    );

    always_comb begin
        out_d           = '0;
        out_d.quick_stb = act.quick;
        out_d.quick_dir = act.quick_dir;
        out_d.wr_stb    = act.commit;
        out_d.wr_len    = act.commit ? cnt : out_q.wr_len;
        out_d.tx_valid  = act.fetch | act.tx_bad;
        out_d.tx_data   = act.fetch ? dev_rd_data_i : 8'hFF;
        out_d.err_stb   = act.err;
        out_d.err_code  = act.err ? act.code : 3'd0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign quick_stb_o = out_q.quick_stb;
    assign quick_dir_o = out_q.quick_dir;
    assign wr_stb_o    = out_q.wr_stb;
    assign wr_len_o    = out_q.wr_len;
    assign wr_cmd_o    = wr_data_o[7:0];
    assign fetch_stb_o = act.fetch;
    assign tx_valid_o  = out_q.tx_valid;
    assign tx_data_o   = out_q.tx_data;
    assign err_stb_o   = out_q.err_stb;
    assign err_code_o  = out_q.err_code;

    // R4 / R5: one stop yields either a commit or a quick command, never both
    assert_one_action_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(quick_stb_o && wr_stb_o));

    // R7: a transmit byte not backed by a fetch carries the idle pattern
    assert_tx_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !$past(fetch_stb_o)) |-> (tx_data_o == 8'hFF));

    // R5: the quick strobe lasts a single cycle
    assert_quick_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        quick_stb_o |=> !quick_stb_o);

    // R4: a committed block is never empty
    assert_commit_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> (wr_len_o != '0));

endmodule

// File: tb/smbus_txn_framer_test.sv
module smbus_txn_framer_test;

    localparam int DEPTH = 34;
    localparam int LENW  = $clog2(DEPTH + 1);
    localparam int E_WR = 1, E_RD = 2, E_STOP = 4, E_NACK = 8, E_BYTE = 16, E_TX = 32;

    logic clk = 1'b0;
    logic rst_n;
    logic start_wr, start_rd, stop, nack, rx_valid, tx_req;
    logic [7:0] rx_byte, dev_rd_data;
    logic quick_stb, quick_dir, wr_stb, fetch_stb, tx_valid, err_stb;
    logic [7:0] wr_cmd, tx_data;
    logic [LENW-1:0] wr_len;
    logic [DEPTH*8-1:0] wr_data;
    logic [2:0] err_code;
    logic fetch_seen;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    smbus_txn_framer #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n),
        .start_wr_i(start_wr), .start_rd_i(start_rd), .stop_i(stop), .nack_i(nack),
        .rx_valid_i(rx_valid), .rx_byte_i(rx_byte), .tx_req_i(tx_req),
        .dev_rd_data_i(dev_rd_data),
        .quick_stb_o(quick_stb), .quick_dir_o(quick_dir),
        .wr_stb_o(wr_stb), .wr_cmd_o(wr_cmd), .wr_len_o(wr_len), .wr_data_o(wr_data),
        .fetch_stb_o(fetch_stb), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
        .err_stb_o(err_stb), .err_code_o(err_code)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // drive at a falling edge, catch the combinational fetch, then land on the next falling edge
    task automatic pulse(input int m, input logic [7:0] b, input logic [7:0] rd);
        start_wr = m[0]; start_rd = m[1]; stop = m[2];
        nack = m[3]; rx_valid = m[4]; tx_req = m[5];
        rx_byte = b; dev_rd_data = rd;
        #1 fetch_seen = fetch_stb;
        @(negedge clk);
        start_wr = 0; start_rd = 0; stop = 0; nack = 0; rx_valid = 0; tx_req = 0;
    endtask

    task automatic ev(input int m);
        pulse(m, 8'h00, 8'h00);
    endtask

    task automatic expect_err(input string req, input bit exp_stb, input int exp_code);
        chk(err_stb == exp_stb, req, "err_stb", err_stb, exp_stb);
        if (exp_stb) chk(err_code == exp_code, req, "err_code", err_code, exp_code);
    endtask

    task automatic t_reset;
        chk({quick_stb, wr_stb, fetch_stb, tx_valid, err_stb} == 5'b0, "R1",
            "strobes after reset", {quick_stb, wr_stb, fetch_stb, tx_valid, err_stb}, 0);
    endtask

    task automatic t_quick;
        ev(E_WR);   expect_err("R2", 0, 0);
        ev(E_STOP);
        chk(quick_stb && !quick_dir, "R5", "quick write", {quick_stb, quick_dir}, 2'b10);
        ev(E_RD);   expect_err("R6", 0, 0);
        ev(E_STOP);
        chk(quick_stb && quick_dir, "R5", "quick read", {quick_stb, quick_dir}, 2'b11);
        ev(E_STOP);
        chk(!quick_stb, "R5", "stop in idle silent", quick_stb, 0);
    endtask

    task automatic t_write_block;
        ev(E_WR);
        pulse(E_BYTE, 8'hA5, 0); pulse(E_BYTE, 8'h11, 0); pulse(E_BYTE, 8'h22, 0);
        chk(!wr_stb, "R3", "no commit before stop", wr_stb, 0);
        ev(E_STOP);
        chk(wr_stb, "R4", "wr_stb", wr_stb, 1);
        chk(wr_cmd == 8'hA5, "R4", "wr_cmd", wr_cmd, 8'hA5);
        chk(wr_len == 3, "R4", "wr_len", wr_len, 3);
        chk(wr_data[23:8] == 16'h2211, "R4", "wr_data", wr_data[23:8], 16'h2211);
        chk(!quick_stb, "R4", "no quick", quick_stb, 0);
    endtask

    task automatic t_combined;
        ev(E_WR); pulse(E_BYTE, 8'h40, 0);
        ev(E_RD);
        chk(wr_stb && wr_len == 1 && wr_cmd == 8'h40, "R6", "commit on repeated start",
            {wr_stb, wr_cmd}, 9'h140);
        pulse(E_TX, 0, 8'h5C);
        chk(fetch_seen, "R7", "fetch same cycle", fetch_seen, 1);
        chk(tx_valid && tx_data == 8'h5C, "R7", "tx_data", tx_data, 8'h5C);
        pulse(E_TX, 0, 8'h6D);
        chk(tx_data == 8'h6D, "R7", "second tx_data", tx_data, 8'h6D);
        ev(E_NACK); expect_err("R8", 0, 0);
        ev(E_NACK); expect_err("R8", 0, 0);
        ev(E_STOP);
        chk(!quick_stb && !wr_stb && !err_stb, "R9", "stop from done silent",
            {quick_stb, wr_stb, err_stb}, 0);
        ev(E_WR);   expect_err("R9", 0, 0);
        ev(E_STOP);
        chk(quick_stb, "R9", "count cleared by stop", quick_stb, 1);
    endtask

    task automatic t_empty_read;
        ev(E_WR); ev(E_RD); expect_err("R6", 1, 2);
        ev(E_WR);           expect_err("R11", 1, 0);
        ev(E_NACK);         expect_err("R11", 1, 4);
        pulse(E_TX, 0, 8'h33);
        chk(tx_valid && tx_data == 8'hFF && !fetch_seen, "R7", "tx outside read",
            tx_data, 8'hFF);
        expect_err("R7", 1, 7);
        ev(E_STOP);
        chk(!quick_stb && !err_stb, "R9", "stop from error", {quick_stb, err_stb}, 0);
        ev(E_WR);           expect_err("R11", 0, 0);
        ev(E_STOP);
    endtask

    task automatic t_bad_read_start;
        ev(E_RD); ev(E_RD); expect_err("R6", 1, 1);
        ev(E_STOP);
    endtask

    task automatic t_unexpected_stop;
        ev(E_WR); pulse(E_BYTE, 8'h07, 0); ev(E_RD);
        ev(E_STOP);
        expect_err("R9", 1, 3);
        chk(!wr_stb && !quick_stb, "R9", "no action", {wr_stb, quick_stb}, 0);
    endtask

    task automatic t_overflow;
        int bad = 0;
        ev(E_WR);
        for (int k = 0; k < DEPTH; k++) begin
            pulse(E_BYTE, 8'(k + 1), 0);
            if (err_stb) bad++;
        end
        chk(bad == 0, "R3", "fill without error", bad, 0);
        pulse(E_BYTE, 8'hEE, 0);
        expect_err("R3", 1, 5);
        ev(E_STOP);
        chk(wr_stb && wr_len == LENW'(DEPTH), "R3", "len at full", wr_len, DEPTH);
        chk(wr_data[8*(DEPTH-1) +: 8] == 8'(DEPTH), "R3", "last byte kept",
            wr_data[8*(DEPTH-1) +: 8], DEPTH);
    endtask

    task automatic t_stray;
        pulse(E_BYTE, 8'h99, 0); expect_err("R10", 1, 6);
        ev(E_WR);                expect_err("R10", 0, 0);
        ev(E_STOP);
        chk(quick_stb && !quick_dir, "R10", "byte not buffered", quick_stb, 1);
        ev(E_RD); pulse(E_BYTE, 8'h12, 0); expect_err("R10", 1, 6);
        pulse(E_TX, 0, 8'hC3);
        chk(tx_data == 8'hC3 && !err_stb, "R10", "still reading", tx_data, 8'hC3);
        ev(E_NACK); ev(E_STOP);
    endtask

    task automatic t_bad_nack;
        ev(E_NACK); expect_err("R8", 1, 4);
        ev(E_STOP);
    endtask

    task automatic t_priority;
        ev(E_WR | E_STOP);
        chk(!quick_stb && !err_stb, "R12", "stop beats start", {quick_stb, err_stb}, 0);
        ev(E_WR);   expect_err("R12", 0, 0);
        ev(E_STOP);
        ev(E_RD | E_NACK); expect_err("R12", 0, 0);
        pulse(E_TX | E_BYTE, 8'h01, 8'h44);
        expect_err("R12", 1, 6);
        chk(!tx_valid, "R12", "tx dropped", tx_valid, 0);
        ev(E_STOP);
        chk(quick_stb && quick_dir, "R12", "read start won", {quick_stb, quick_dir}, 2'b11);
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; fetch_seen = 0;
        start_wr = 0; start_rd = 0; stop = 0; nack = 0; rx_valid = 0; tx_req = 0;
        rx_byte = 0; dev_rd_data = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_quick();
        t_write_block();
        t_combined();
        t_empty_read();
        t_bad_read_start();
        t_unexpected_stop();
        t_overflow();
        t_stray();
        t_bad_nack();
        t_priority();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule